// File: doc/BRIEF.md
# Asynchronous Backplane Slave Transfer Controller

This block is the slave end of a strobe-and-acknowledge backplane transfer in which the master shares no clock with the slave. The master first places the address, the address-modifier code, the direction and the access-width qualifiers on the bus. It then pulls the address strobe and one or both data strobes low. The controller brings those strobes into its own clock domain and checks whether the access is meant for it. For its own accesses, it either updates a small internal register file or returns read data, and it then answers with a transfer acknowledge. When the width code cannot be served by the addressed register, it answers with a bus-error indication instead.

The access width comes from the pair of data strobes and the long-word qualifier. A 32-bit access uses the full data bus. Narrower accesses use the low sixteen data lines and pick one half of the addressed register through address bit 1. On the local side there is a plain index/data read port, so surrounding logic can see the register contents. Data-bus tri-state control is brought out as a separate enable and is not built as a bidirectional pin.

Top module: `async_slave_xfer`

## Requirements
- R1: While reset is asserted and right after it is released, the acknowledge and bus-error outputs are high (inactive), the data enable is low, and every register reads zero on the local port.
- R2: A cycle is taken only when the synchronised address strobe and at least one data strobe have been low at two consecutive clock samples. If the strobes are first sampled low at rising edge k, a write acknowledge goes low after edge k+3. A read drives data after edge k+3 and acknowledges after edge k+4.
- R3: The byte address (address bit 0 taken as zero), ANDed with the window mask, must equal the window base (default base 0x400000 with mask 0xFFFFE0). If it does not, the cycle gets no response of any kind and no register changes until both data strobes return high. The register index is taken from address bits 4:2.
- R4: The address-modifier code must be one of the configured codes (default 0x39 or 0x3D). Any other code gets no response and changes no register.
- R5: Width encoding (strobes and qualifier active low). A 32-bit access has the qualifier low, both strobes low and address bit 1 zero. A 16-bit access has the qualifier high and both strobes low; address bit 1 = 0 selects register bits 31:16, and 1 selects bits 15:0, carried on data lines 15:0. A byte access with only data strobe 1 low moves the upper byte of the selected half on lines 15:8. A byte access with only data strobe 0 low moves the lower byte on lines 7:0.
- R6: Bus error (never acknowledge) is returned in these cases, and no register is written and no data is driven:
  - the qualifier is low with only one strobe;
  - the qualifier is low with address bit 1 set;
  - any access narrower than 32 bits goes to a register marked full-width only (default: register 0).
- R7: An accepted write changes exactly the selected bytes. The new value is visible on the local read port from the edge that asserts the acknowledge.
- R8: An accepted read drives the data enable for at least one clock before the acknowledge goes low. Byte lanes not selected read as zero, and the value on the data inputs has no effect.
- R9: The acknowledge or bus error stays low until both data strobes are sampled high after synchronisation. It is then released in the same cycle as the data enable, and it stays high for at least one clock before any further response.
- R10: The acknowledge and the bus error are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_ni | input | 1 | Address strobe, active low |
| ds0_ni | input | 1 | Data strobe for lines 7:0, active low |
| ds1_ni | input | 1 | Data strobe for lines 15:8, active low |
| lword_ni | input | 1 | Long-word qualifier, active low |
| write_ni | input | 1 | Low for write, high for read |
| am_i | input | 6 | Address-modifier code |
| addr_i | input | AW-1 | Address bits AW-1 down to 1 |
| data_i | input | 32 | Data from the bus |
| data_o | output | 32 | Read data toward the bus |
| data_oe_o | output | 1 | Enable for the read-data drivers |
| dtack_no | output | 1 | Transfer acknowledge, active low |
| berr_no | output | 1 | Bus error, active low |
| loc_idx_i | input | $clog2(NREGS) | Local read index |
| loc_rdata_o | output | 32 | Local read data |

## Verification
The assertions check on every cycle that the two response lines never overlap and that read data is enabled a cycle before the acknowledge. They also check that the bus-error path never enables the drivers, that a response is held while a data strobe was recently low, and that a release always leaves a one-clock gap with the drivers off. Only the bench scenarios can show the rest:
- which accesses hit the address window and the modifier set;
- how each width code maps onto register bytes and data lanes;
- that ignored and erroring accesses leave the register file untouched.

The bench shows these through a cycle-level reference model and through read-back over the bus and the local port.

// File: rtl/slv_pkg.sv
package slv_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_ACK,
    ST_ERR,
    ST_SKIP
  } slv_state_e;

  typedef struct packed {
    logic          hit;
    logic          legal;
    logic          upper;
    logic [NB-1:0] be;
  } slv_dec_t;

  function automatic logic [DW-1:0] be_mask(input logic [NB-1:0] be);
    logic [DW-1:0] m;
    for (int b = 0; b < NB; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/slv_sync.sv
module slv_sync #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/slv_decode.sv
module slv_decode
  import slv_pkg::*;
#(
  parameter int                    AW        = 24,
  parameter int                    NREGS     = 8,
  parameter logic [AW-1:0]         BASE      = 24'h40_0000,
  parameter logic [AW-1:0]         MASK      = 24'hFF_FFE0,
  parameter int                    NAM       = 2,
  parameter logic [NAM-1:0][5:0]   AM_OK     = {6'h3D, 6'h39},
  parameter logic [NREGS-1:0]      FULL_ONLY = NREGS'(1),
  localparam int                   IDXW      = $clog2(NREGS)
) (
  input  logic [AW-1:1]   addr_i,
  input  logic [5:0]      am_i,
  input  logic            lword_ni,
  input  logic            ds0_ni,
  input  logic            ds1_ni,
  output slv_dec_t        dec_o,
  output logic [IDXW-1:0] idx_o
);
  logic [AW-1:0]  byte_addr;
  logic           win_hit, in_rng, a01, full;
  logic [NAM-1:0] am_match;
  logic [1:0]     lanes;

  assign byte_addr = {addr_i, 1'b0};
  assign win_hit   = (byte_addr & MASK) == BASE;
  assign idx_o     = addr_i[IDXW+1:2];
  assign a01       = addr_i[1];
  assign full      = !lword_ni;
  assign lanes     = {!ds1_ni, !ds0_ni};

  for (genvar g = 0; g < NAM; g++) begin : g_am
    assign am_match[g] = (am_i == AM_OK[g]);
  end

  if (NREGS == (1 << IDXW)) begin : g_pow2
    assign in_rng = 1'b1;
  end else begin : g_npow2
    assign in_rng = {1'b0, idx_o} < (IDXW+1)'(NREGS);
  end

  always_comb begin
    dec_o.hit   = win_hit && (|am_match) && in_rng;
    dec_o.upper = !full && !a01;
    if (full) begin
      dec_o.be    = '1;
      dec_o.legal = (&lanes) && !a01;
    end else begin
      dec_o.be    = a01 ? {2'b00, lanes} : {lanes, 2'b00};
      dec_o.legal = |lanes;
      if (FULL_ONLY[idx_o]) dec_o.legal = 1'b0;
    end
  end
endmodule

// File: rtl/slv_regfile.sv
module slv_regfile
  import slv_pkg::*;
#(
  parameter int  NREGS = 8,
  localparam int IDXW  = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IDXW-1:0] widx_i,
  input  logic [NB-1:0]   be_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [IDXW-1:0] ridx_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [IDXW-1:0] loc_idx_i,
  output logic [DW-1:0]   loc_rdata_o
);
  logic [DW-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREGS; r++) regs_q[r] <= '0;
    end else if (we_i) begin
      for (int r = 0; r < NREGS; r++) begin
        if (widx_i == IDXW'(r)) begin
          for (int b = 0; b < NB; b++) begin
            if (be_i[b]) regs_q[r][8*b +: 8] <= wdata_i[8*b +: 8];
          end
        end
      end
    end
  end

  assign rdata_o     = regs_q[ridx_i];
  assign loc_rdata_o = regs_q[loc_idx_i];
endmodule

// File: rtl/async_slave_xfer.sv
module async_slave_xfer
  import slv_pkg::*;
#(
  parameter int                  AW        = 24,
  parameter int                  NREGS     = 8,
  parameter logic [AW-1:0]       BASE      = 24'h40_0000,
  parameter logic [AW-1:0]       MASK      = 24'hFF_FFE0,
  parameter int                  NAM       = 2,
  parameter logic [NAM-1:0][5:0] AM_OK     = {6'h3D, 6'h39},
  parameter logic [NREGS-1:0]    FULL_ONLY = NREGS'(1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     as_ni,
  input  logic                     ds0_ni,
  input  logic                     ds1_ni,
  input  logic                     lword_ni,
  input  logic                     write_ni,
  input  logic [5:0]               am_i,
  input  logic [AW-1:1]            addr_i,
  input  logic [31:0]              data_i,
  output logic [31:0]              data_o,
  output logic                     data_oe_o,
  output logic                     dtack_no,
  output logic                     berr_no,
  input  logic [$clog2(NREGS)-1:0] loc_idx_i,
  output logic [31:0]              loc_rdata_o
);
  localparam int IDXW = $clog2(NREGS);
  localparam int HW   = DW / 2;

  slv_state_e      state_q;
  logic [2:0]      strb_raw, strb_s2, strb_s3_q;
  logic            qual, rel, accept, we;
  slv_dec_t        dec;
  logic [IDXW-1:0] idx;
  logic [DW-1:0]   reg_rd, rd_masked, rd_fmt, wr_aligned, rdata_q;
  logic            drv_q;

  // {ds1, ds0, as}: active when AS low and any data strobe low
  function automatic logic strb_act(input logic [2:0] v);
    return !v[0] && !(v[1] && v[2]);
  endfunction

  assign strb_raw = {ds1_ni, ds0_ni, as_ni};

  slv_sync #(.W(3), .RST_VAL(3'b111)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (strb_raw),
    .q_o   (strb_s2)
  );

  assign qual = strb_act(strb_s2) && strb_act(strb_s3_q);
  assign rel  = strb_s2[1] && strb_s2[2];

  slv_decode #(
    .AW(AW), .NREGS(NREGS), .BASE(BASE), .MASK(MASK),
    .NAM(NAM), .AM_OK(AM_OK), .FULL_ONLY(FULL_ONLY)
  ) i_decode (
    .addr_i  (addr_i),
    .am_i    (am_i),
    .lword_ni(lword_ni),
    .ds0_ni  (ds0_ni),
    .ds1_ni  (ds1_ni),
    .dec_o   (dec),
    .idx_o   (idx)
  );

  assign accept = (state_q == ST_IDLE) && qual;
  assign we     = accept && dec.hit && dec.legal && !write_ni;

  // narrow data rides on lines 15:0 and lands in the half picked by A01
  always_comb begin
    if (!lword_ni)      wr_aligned = data_i;
    else if (dec.upper) wr_aligned = {data_i[HW-1:0], {HW{1'b0}}};
    else                wr_aligned = {{HW{1'b0}}, data_i[HW-1:0]};
  end

  slv_regfile #(.NREGS(NREGS)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we),
    .widx_i     (idx),
    .be_i       (dec.be),
    .wdata_i    (wr_aligned),
    .ridx_i     (idx),
    .rdata_o    (reg_rd),
    .loc_idx_i  (loc_idx_i),
    .loc_rdata_o(loc_rdata_o)
  );

  assign rd_masked = reg_rd & be_mask(dec.be);
  assign rd_fmt    = dec.upper ? (rd_masked >> HW) : rd_masked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      strb_s3_q <= 3'b111;
      rdata_q   <= '0;
      drv_q     <= 1'b0;
    end else begin
      strb_s3_q <= strb_s2;
      case (state_q)
        ST_IDLE: begin
          if (qual) begin
            if (!dec.hit)        state_q <= ST_SKIP;
            else if (!dec.legal) state_q <= ST_ERR;
            else if (!write_ni)  state_q <= ST_ACK;
            else begin
              state_q <= ST_DRIVE;
              drv_q   <= 1'b1;
              rdata_q <= rd_fmt;
            end
          end
        end
        ST_DRIVE: state_q <= ST_ACK;
        default: begin
          if (rel) begin
            state_q <= ST_IDLE;
            drv_q   <= 1'b0;
          end
        end
      endcase
    end
  end

  assign dtack_no  = (state_q != ST_ACK);
  assign berr_no   = (state_q != ST_ERR);
  assign data_oe_o = drv_q;
  assign data_o    = rdata_q;
endmodule

// File: rtl/async_slave_xfer_chk.sv
module async_slave_xfer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic as_ni,
  input logic ds0_ni,
  input logic ds1_ni,
  input logic dtack_no,
  input logic berr_no,
  input logic data_oe_o
);
  // R10
  excl_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dtack_no && !berr_no));

  // R8
  drive_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dtack_no) && data_oe_o) |-> $past(data_oe_o));

  // R6
  berr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !berr_no |-> !data_oe_o);

  // R9
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_no && ($past(!ds0_ni, 2) || $past(!ds1_ni, 2))) |=> !dtack_no);

  // R9
  berr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!berr_no && ($past(!ds0_ni, 2) || $past(!ds1_ni, 2))) |=> !berr_no);

  // R9
  release_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dtack_no) |-> !data_oe_o);

  // R9
  rearm_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dtack_no) |=> dtack_no);

  // R2
  write_needs_as_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dtack_no) && !data_oe_o) |-> $past(!as_ni, 3));
endmodule

bind async_slave_xfer async_slave_xfer_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .as_ni    (as_ni),
  .ds0_ni   (ds0_ni),
  .ds1_ni   (ds1_ni),
  .dtack_no (dtack_no),
  .berr_no  (berr_no),
  .data_oe_o(data_oe_o)
);

// File: tb/test_async_slave_xfer.sv
`timescale 1ns/1ps
module test_async_slave_xfer;
  localparam int WD_LIMIT = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        as_ni = 1'b1, ds0_ni = 1'b1, ds1_ni = 1'b1;
  logic        lword_ni = 1'b1, write_ni = 1'b1;
  logic [5:0]  am_i = 6'h39;
  logic [23:1] addr_i = '0;
  logic [31:0] data_i = '0;
  logic [31:0] data_o, loc_rdata_o;
  logic        data_oe_o, dtack_no, berr_no;
  logic [2:0]  loc_idx_i = '0;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #5 clk_i = ~clk_i;

  async_slave_xfer i_async_slave_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .as_ni(as_ni), .ds0_ni(ds0_ni),
    .ds1_ni(ds1_ni), .lword_ni(lword_ni), .write_ni(write_ni), .am_i(am_i),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .dtack_no(dtack_no), .berr_no(berr_no), .loc_idx_i(loc_idx_i),
    .loc_rdata_o(loc_rdata_o)
  );

  task automatic cmp(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t: got %h expected %h", req, cur_req, $time, got, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // behavioural reference: state 0 idle, 1 drive, 2 ack, 3 error, 4 ignore
  int          m_st = 0;
  logic        m_oe = 1'b0;
  logic [31:0] m_data = '0;
  logic [31:0] m_regs [8];
  bit          h_act1, h_act2, h_act3;
  bit          h_rel1 = 1, h_rel2 = 1, h_rel3 = 1;
  logic [23:0] ba;
  int          idx, hb, lb;
  bit          hit, legal, a01;

  initial for (int r = 0; r < 8; r++) m_regs[r] = '0;

  always @(posedge clk_i) begin
    cyc++;
    loc_idx_i <= loc_idx_i + 3'd1;
    if (!rst_ni) begin
      m_st = 0; m_oe = 0; m_data = '0;
      h_act1 = 0; h_act2 = 0; h_act3 = 0;
      h_rel1 = 1; h_rel2 = 1; h_rel3 = 1;
      for (int r = 0; r < 8; r++) m_regs[r] = '0;
    end else begin
      case (m_st)
        0: if (h_act2 && h_act3) begin
          ba  = {addr_i, 1'b0};
          idx = int'(ba[4:2]);
          a01 = ba[1];
          hit = (ba[23:5] == 19'h20000) && (am_i == 6'h39 || am_i == 6'h3D);
          if (!lword_ni) legal = !ds0_ni && !ds1_ni && !a01;
          else           legal = (idx != 0);
          hb = a01 ? 1 : 3;
          lb = a01 ? 0 : 2;
          if (!hit) m_st = 4;
          else if (!legal) m_st = 3;
          else if (!write_ni) begin
            if (!lword_ni) m_regs[idx] = data_i;
            else begin
              if (!ds1_ni) m_regs[idx][8*hb +: 8] = data_i[15:8];
              if (!ds0_ni) m_regs[idx][8*lb +: 8] = data_i[7:0];
            end
            m_st = 2;
          end else begin
            if (!lword_ni) m_data = m_regs[idx];
            else begin
              m_data = '0;
              if (!ds1_ni) m_data[15:8] = m_regs[idx][8*hb +: 8];
              if (!ds0_ni) m_data[7:0]  = m_regs[idx][8*lb +: 8];
            end
            m_oe = 1; m_st = 1;
          end
        end
        1: m_st = 2;
        default: if (h_rel2) begin m_st = 0; m_oe = 0; end
      endcase
      h_act3 = h_act2; h_act2 = h_act1;
      h_act1 = !as_ni && (!ds0_ni || !ds1_ni);
      h_rel3 = h_rel2; h_rel2 = h_rel1;
      h_rel1 = ds0_ni && ds1_ni;
    end
    if (cyc == WD_LIMIT && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  always @(negedge clk_i) begin
    if (cyc > 0 && !done) begin
      cmp("R2", {31'b0, dtack_no}, {31'b0, m_st != 2});
      cmp("R6", {31'b0, berr_no}, {31'b0, m_st != 3});
      cmp("R8", {31'b0, data_oe_o}, {31'b0, m_oe});
      if (m_oe) cmp("R8", data_o, m_data);
      cmp("R7", loc_rdata_o, m_regs[loc_idx_i]);
      cmp("R10", {31'b0, !dtack_no && !berr_no}, 32'd0);
    end
  end

  // resp: 0 none, 1 acknowledge, 2 bus error
  task automatic xfer(input string req, input bit wr, input bit lw_n, input bit d1_n,
                      input bit d0_n, input logic [5:0] am, input logic [23:0] addr,
                      input logic [31:0] wd, input int hold, input int exp_resp,
                      input logic [31:0] exp_rd);
    int resp = 0;
    logic [31:0] rd = '0;
    cur_req = req;
    @(negedge clk_i);
    addr_i = addr[23:1]; am_i = am; write_ni = !wr; lword_ni = lw_n;
    data_i = wr ? wd : 32'hFFFF_FFFF;
    @(negedge clk_i);
    as_ni = 1'b0; ds1_ni = d1_n; ds0_ni = d0_n;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      if (!dtack_no) begin resp = 1; rd = data_o; break; end
      if (!berr_no)  begin resp = 2; break; end
    end
    cmp(req, resp, exp_resp);
    if (!wr && exp_resp == 1) cmp(req, rd, exp_rd);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk_i);
      if (resp == 1) cmp("R9", {31'b0, dtack_no}, 32'd0);
    end
    ds0_ni = 1'b1; ds1_ni = 1'b1; as_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    cmp("R9", {31'b0, dtack_no}, 32'd1);
    cmp("R9", {31'b0, berr_no}, 32'd1);
    cmp("R9", {31'b0, data_oe_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    cmp("R1", {31'b0, dtack_no}, 32'd1);
    cmp("R1", {31'b0, berr_no}, 32'd1);
    cmp("R1", {31'b0, data_oe_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    cmp("R1", loc_rdata_o, 32'd0);

    // full-width write/read
    xfer("R2", 1, 0, 0, 0, 6'h39, 24'h400004, 32'hDEAD_BEEF, 0, 1, 0);
    xfer("R8", 0, 0, 0, 0, 6'h39, 24'h400004, 0, 0, 1, 32'hDEAD_BEEF);
    // half-word writes
    xfer("R5", 1, 1, 0, 0, 6'h39, 24'h400008, 32'h0000_1234, 0, 1, 0);
    xfer("R5", 1, 1, 0, 0, 6'h39, 24'h40000A, 32'h0000_5678, 0, 1, 0);
    xfer("R5", 0, 0, 0, 0, 6'h39, 24'h400008, 0, 0, 1, 32'h1234_5678);
    // byte writes
    xfer("R7", 1, 1, 0, 1, 6'h39, 24'h40000C, 32'h0000_AA00, 0, 1, 0);
    xfer("R7", 1, 1, 1, 0, 6'h39, 24'h40000E, 32'h0000_0055, 0, 1, 0);
    xfer("R7", 0, 0, 0, 0, 6'h39, 24'h40000C, 0, 0, 1, 32'hAA00_0055);
    // narrow reads
    xfer("R5", 0, 1, 0, 0, 6'h39, 24'h400004, 0, 0, 1, 32'h0000_DEAD);
    xfer("R8", 0, 1, 0, 1, 6'h39, 24'h400006, 0, 0, 1, 32'h0000_BE00);
    xfer("R8", 0, 1, 1, 0, 6'h39, 24'h400006, 0, 0, 1, 32'h0000_00EF);
    // window misses
    xfer("R3", 1, 0, 0, 0, 6'h39, 24'h400024, 32'h1111_1111, 0, 0, 0);
    xfer("R3", 1, 0, 0, 0, 6'h39, 24'h500004, 32'h2222_2222, 0, 0, 0);
    xfer("R3", 0, 0, 0, 0, 6'h39, 24'h400004, 0, 0, 1, 32'hDEAD_BEEF);
    // modifier codes
    xfer("R4", 1, 0, 0, 0, 6'h09, 24'h400004, 32'h3333_3333, 0, 0, 0);
    xfer("R4", 0, 0, 0, 0, 6'h39, 24'h400004, 0, 0, 1, 32'hDEAD_BEEF);
    xfer("R4", 1, 0, 0, 0, 6'h3D, 24'h400010, 32'h0BAD_F00D, 0, 1, 0);
    // illegal widths
    xfer("R6", 1, 0, 1, 0, 6'h39, 24'h400010, 32'h4444_4444, 0, 2, 0);
    xfer("R6", 1, 0, 0, 0, 6'h39, 24'h400012, 32'h5555_5555, 0, 2, 0);
    xfer("R6", 1, 1, 0, 0, 6'h39, 24'h400002, 32'h0000_6666, 0, 2, 0);
    xfer("R6", 0, 1, 0, 0, 6'h39, 24'h400000, 0, 0, 2, 0);
    xfer("R6", 0, 0, 0, 0, 6'h39, 24'h400010, 0, 0, 1, 32'h0BAD_F00D);
    xfer("R6", 0, 0, 0, 0, 6'h39, 24'h400000, 0, 0, 1, 32'h0000_0000);
    xfer("R6", 1, 0, 0, 0, 6'h39, 24'h400000, 32'h7777_0000, 0, 1, 0);
    // long strobe hold, then back-to-back reuse
    xfer("R9", 1, 0, 0, 0, 6'h39, 24'h400014, 32'hCAFE_0001, 10, 1, 0);
    xfer("R9", 0, 0, 0, 0, 6'h39, 24'h400014, 0, 10, 1, 32'hCAFE_0001);
    xfer("R10", 0, 0, 0, 0, 6'h39, 24'h400000, 0, 0, 1, 32'h7777_0000);

    repeat (8) @(negedge clk_i);
    finish_run();
  end
endmodule